// File: doc/BRIEF.md
# MII Transmit Framer

The framer sits between a byte-wide frame source and a 4-bit MII transmit port running at 25 MHz for 100 Mbit/s links. The source presents a complete Ethernet frame, from destination address through FCS, as a stream of bytes with valid, last and ready. The framer puts the 0x55 preamble and the start-of-frame delimiter 0xD5 in front of it, sends each byte as two nibbles with the low nibble first, and holds the idle gap between frames.

Transmit enable is treated as a framing contract: once it rises it stays high until the high nibble of the last byte has gone out. If the source has no byte ready when one is due, the framer does not drop enable. It sends a filler nibble, raises the error line for the rest of that frame and flags the underrun, so the PHY discards the frame instead of seeing it split in two.

Top module: `mii_tx_framer`

## Requirements
- R1: While reset is asserted and after it is released with no input, `mii_tx_en`, `mii_tx_er`, `mii_txd` and `s_ready` are all zero.
- R2: A frame opens with 16 nibbles on `mii_txd`: fifteen of value 0x5 followed by one of value 0xD, with `mii_tx_en` high and `mii_tx_er` low.
- R3: After the delimiter, each input byte goes out in two consecutive cycles, bits [3:0] first and then bits [7:4].
- R4: `s_ready` is high only in the cycle that carries the second nibble of a byte, and the byte is taken at the end of that cycle.
- R5: `mii_tx_en` stays high without a gap from the first preamble nibble until the cycle after the byte marked `s_last` is accepted, when it falls. A frame of N bytes with F filler nibbles lasts 16 + 2N + F cycles.
- R6: If `s_valid` is low when the first nibble of a byte is due, that cycle carries a filler nibble 0x0 with `mii_tx_en` high, `mii_tx_er` high and `underrun` high. The byte is sent whole once it arrives.
- R7: After an underrun, `mii_tx_er` stays high for every remaining nibble of that frame and is low again from the start of the next frame.
- R8: After `mii_tx_en` falls it stays low for at least 24 cycles. If the next frame is already offered by the 24th low cycle, its first preamble nibble appears in the 25th cycle.
- R9: While `mii_tx_en` is low, `mii_txd` is 0x0, `mii_tx_er` is low and `s_ready` is low, so a byte offered during the gap is not taken.
- R10: In idle, the framer waits as long as `s_valid` is low and starts the preamble in the cycle after `s_valid` is first seen high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit clock, 25 MHz at 100 Mbit/s |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| s_data | input | 8 | Frame byte from the source |
| s_valid | input | 1 | Source has a byte on `s_data` |
| s_last | input | 1 | Byte on `s_data` is the last of its frame |
| s_ready | output | 1 | Byte on `s_data` is taken at this clock edge |
| mii_txd | output | 4 | Transmit nibble |
| mii_tx_en | output | 1 | Transmit enable, high for the whole frame |
| mii_tx_er | output | 1 | Transmit error, high on nibbles the PHY must reject |
| underrun | output | 1 | High in each cycle a filler nibble replaces a missing byte |

## Verification
A wrong preamble counter shows up within the first 16 cycles of a frame as a wrong nibble count before the delimiter. A wrong half-byte bit swaps nibbles or shifts `s_ready` by one cycle on the very first data byte. A gap counter that is off by one makes back-to-back frames start one cycle early or late, which is visible at the next rising edge of enable. An error flag that is not cleared shows up as `mii_tx_er` high on the first data nibble of the frame that follows an underrun. A flag that is not set shows up one cycle after the filler.

// File: rtl/mii_tx_pkg.sv
package mii_tx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRE  = 2'd1,
    ST_DATA = 2'd2,
    ST_GAP  = 2'd3
  } tx_state_e;

  localparam logic [3:0] NIB_PRE    = 4'h5;
  localparam logic [3:0] NIB_SFD_HI = 4'hD;
  localparam logic [3:0] NIB_IDLE   = 4'h0;
  localparam logic [3:0] NIB_FILL   = 4'h0;

endpackage

// File: rtl/mii_tx_rst_sync.sv
module mii_tx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= sync_d;
  end

  assign rst_n_out = sync_q[STAGES-1];

endmodule

// File: rtl/mii_tx_counter.sv
module mii_tx_counter #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] count
);

  logic [W-1:0] count_d;

  always_comb begin
    count_d = count;
    if (clr)     count_d = '0;
    else if (en) count_d = count + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= count_d;
  end

endmodule

// File: rtl/mii_tx_seq.sv
module mii_tx_seq
  import mii_tx_pkg::*;
#(
  parameter int PRE_NIBS = 16,
  parameter int GAP_CLKS = 24,
  parameter int CW       = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_valid,
  input  logic          s_last,
  input  logic [CW-1:0] count,
  output tx_state_e     state_q,
  output logic          half_q,
  output logic          err_q,
  output logic          cnt_clr,
  output logic          cnt_en,
  output logic          pre_last,
  output logic          underrun,
  output logic          s_ready
);

  localparam logic [CW-1:0] PRE_END = CW'(PRE_NIBS - 1);
  localparam logic [CW-1:0] GAP_END = CW'(GAP_CLKS - 1);

  tx_state_e state_d;
  logic      half_d;
  logic      err_d;
  logic      gap_last;

  always_comb begin
    pre_last = (state_q == ST_PRE) && (count == PRE_END);
    gap_last = (state_q == ST_GAP) && (count == GAP_END);
    underrun = (state_q == ST_DATA) && !half_q && !s_valid;
    s_ready  = (state_q == ST_DATA) && half_q;

    state_d = state_q;
    half_d  = half_q;
    err_d   = err_q;
    cnt_clr = 1'b0;
    cnt_en  = 1'b0;

    unique case (state_q)
      ST_IDLE: begin
        if (s_valid) begin
          state_d = ST_PRE;
          cnt_clr = 1'b1;
          err_d   = 1'b0;
        end
      end
      ST_PRE: begin
        cnt_en = 1'b1;
        if (pre_last) begin
          state_d = ST_DATA;
          half_d  = 1'b0;
        end
      end
      ST_DATA: begin
        if (half_q) begin
          half_d = 1'b0;
          if (s_valid && s_last) begin
            state_d = ST_GAP;
            cnt_clr = 1'b1;
          end
        end else if (s_valid) begin
          half_d = 1'b1;
        end else begin
          err_d = 1'b1;
        end
      end
      ST_GAP: begin
        cnt_en = 1'b1;
        if (gap_last) begin
          if (s_valid) begin
            state_d = ST_PRE;
            cnt_clr = 1'b1;
            err_d   = 1'b0;
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      half_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      half_q  <= half_d;
      err_q   <= err_d;
    end
  end

endmodule

// File: rtl/mii_tx_nib_sel.sv
module mii_tx_nib_sel
  import mii_tx_pkg::*;
(
  input  tx_state_e   state,
  input  logic        pre_last,
  input  logic        half,
  input  logic        err,
  input  logic        underrun,
  input  logic [7:0]  data,
  output logic [3:0]  txd,
  output logic        tx_en,
  output logic        tx_er
);

  always_comb begin
    txd   = NIB_IDLE;
    tx_en = 1'b0;
    tx_er = 1'b0;
    case (state)
      ST_PRE: begin
        tx_en = 1'b1;
        txd   = pre_last ? NIB_SFD_HI : NIB_PRE;
      end
      ST_DATA: begin
        tx_en = 1'b1;
        tx_er = err | underrun;
        if (underrun) txd = NIB_FILL;
        else          txd = half ? data[7:4] : data[3:0];
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/mii_tx_framer.sv
module mii_tx_framer
  import mii_tx_pkg::*;
#(
  parameter int PRE_BYTES   = 7,
  parameter int GAP_CLKS    = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] s_data,
  input  logic       s_valid,
  input  logic       s_last,
  output logic       s_ready,
  output logic [3:0] mii_txd,
  output logic       mii_tx_en,
  output logic       mii_tx_er,
  output logic       underrun
);

  localparam int PRE_NIBS = 2 * PRE_BYTES + 2;
  localparam int CNT_TOP  = (PRE_NIBS > GAP_CLKS) ? PRE_NIBS : GAP_CLKS;
  localparam int CW       = $clog2(CNT_TOP);

  logic          rst_n_sync;
  logic [CW-1:0] count;
  logic          cnt_clr;
  logic          cnt_en;
  tx_state_e     state;
  logic          half;
  logic          err;
  logic          pre_last;

  mii_tx_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_sync)
  );

  mii_tx_counter #(.W(CW)) u_counter (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .clr   (cnt_clr),
    .en    (cnt_en),
    .count (count)
  );

  mii_tx_seq #(
    .PRE_NIBS (PRE_NIBS),
    .GAP_CLKS (GAP_CLKS),
    .CW       (CW)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .s_valid  (s_valid),
    .s_last   (s_last),
    .count    (count),
    .state_q  (state),
    .half_q   (half),
    .err_q    (err),
    .cnt_clr  (cnt_clr),
    .cnt_en   (cnt_en),
    .pre_last (pre_last),
    .underrun (underrun),
    .s_ready  (s_ready)
  );

  mii_tx_nib_sel u_nib_sel (
    .state    (state),
    .pre_last (pre_last),
    .half     (half),
    .err      (err),
    .underrun (underrun),
    .data     (s_data),
    .txd      (mii_txd),
    .tx_en    (mii_tx_en),
    .tx_er    (mii_tx_er)
  );

endmodule

// File: rtl/mii_tx_framer_chk.sv
module mii_tx_framer_chk #(
  parameter int PRE_BYTES = 7,
  parameter int GAP_CLKS  = 24
) (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] s_data,
  input logic       s_valid,
  input logic       s_last,
  input logic       s_ready,
  input logic [3:0] mii_txd,
  input logic       mii_tx_en,
  input logic       mii_tx_er,
  input logic       underrun
);

  localparam int PRE_NIBS = 2 * PRE_BYTES + 2;

  logic [15:0] hi_cnt;
  logic [15:0] low_cnt;
  logic        seen_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt    <= '0;
      low_cnt   <= '0;
      seen_fall <= 1'b0;
    end else begin
      if (mii_tx_en) begin
        low_cnt <= '0;
        if (hi_cnt != 16'hFFFF) hi_cnt <= hi_cnt + 16'd1;
      end else begin
        hi_cnt <= '0;
        if (low_cnt != 16'hFFFF) low_cnt <= low_cnt + 16'd1;
      end
      if ($fell(mii_tx_en)) seen_fall <= 1'b1;
    end
  end

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mii_tx_en |-> (mii_txd == 4'h0 && !mii_tx_er && !s_ready));

  // R2
  preamble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mii_tx_en && hi_cnt < 16'(PRE_NIBS)) |->
      (!mii_tx_er && mii_txd == ((hi_cnt == 16'(PRE_NIBS - 1)) ? 4'hD : 4'h5)));

  // R4
  ready_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> (mii_tx_en && hi_cnt >= 16'(PRE_NIBS + 1)));

  // R5
  en_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mii_tx_en) |-> $past(s_ready && s_valid && s_last));

  // R6
  underrun_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> (mii_tx_en && mii_tx_er && !s_ready && mii_txd == 4'h0));

  // R7
  er_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mii_tx_en && $past(mii_tx_en && mii_tx_er)) |-> mii_tx_er);

  // R8
  gap_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mii_tx_en) && seen_fall) |-> (low_cnt >= 16'(GAP_CLKS)));

endmodule

bind mii_tx_framer mii_tx_framer_chk #(
  .PRE_BYTES (PRE_BYTES),
  .GAP_CLKS  (GAP_CLKS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .s_data    (s_data),
  .s_valid   (s_valid),
  .s_last    (s_last),
  .s_ready   (s_ready),
  .mii_txd   (mii_txd),
  .mii_tx_en (mii_tx_en),
  .mii_tx_er (mii_tx_er),
  .underrun  (underrun)
);

// File: tb/test_mii_tx_framer.sv
module test_mii_tx_framer;

  localparam int GAP = 24;

  logic       clk;
  logic       rst_n;
  logic [7:0] s_data;
  logic       s_valid;
  logic       s_last;
  logic       s_ready;
  logic [3:0] mii_txd;
  logic       mii_tx_en;
  logic       mii_tx_er;
  logic       underrun;

  int n_checks = 0;
  int n_fail   = 0;
  int frames_sent = 0;

  logic [3:0] exp_nib_q[$];
  bit         exp_er_q[$];
  bit         exp_un_q[$];
  int         exp_len_q[$];
  int         exp_gap_q[$];

  mii_tx_framer i_mii_tx_framer (
    .clk       (clk),
    .rst_n     (rst_n),
    .s_data    (s_data),
    .s_valid   (s_valid),
    .s_last    (s_last),
    .s_ready   (s_ready),
    .mii_txd   (mii_txd),
    .mii_tx_en (mii_tx_en),
    .mii_tx_er (mii_tx_er),
    .underrun  (underrun)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string msg);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s", msg);
    end
  endtask

  function automatic int exp_gap(input int idle);
    return (idle + 1 > GAP) ? idle + 1 : GAP;
  endfunction

  // monitor: samples 1 ns after the falling edge, when all drives have settled
  bit    in_frame = 0;
  bit    have_prev = 0;
  int    flen = 0;
  int    low = 0;
  int    quiet_err = 0;
  bit    ferr = 0;
  string fmsg;

  always begin
    @(negedge clk);
    #1;
    if (rst_n) begin
      if (mii_tx_en) begin
        if (!in_frame) begin
          in_frame = 1; flen = 0; ferr = 0; fmsg = "";
          if (have_prev) begin
            int eg;
            eg = (exp_gap_q.size() > 0) ? exp_gap_q.pop_front() : -1;
            check(low == eg, $sformatf("R8 gap cycles actual=%0d expected=%0d", low, eg));
            check(quiet_err == 0, $sformatf("R9 gap activity actual=%0d expected=0", quiet_err));
          end
        end
        if (exp_nib_q.size() == 0) begin
          if (!ferr) fmsg = $sformatf("nibble %0d actual=%h expected=none", flen, mii_txd);
          ferr = 1;
        end else begin
          logic [3:0] en_v; bit er_v; bit un_v;
          en_v = exp_nib_q.pop_front(); er_v = exp_er_q.pop_front(); un_v = exp_un_q.pop_front();
          if (mii_txd != en_v || mii_tx_er != er_v || underrun != un_v) begin
            if (!ferr) fmsg = $sformatf("nibble %0d actual=%h/er%0d/un%0d expected=%h/er%0d/un%0d",
                                        flen, mii_txd, mii_tx_er, underrun, en_v, er_v, un_v);
            ferr = 1;
          end
        end
        flen++;
      end else begin
        if (in_frame) begin
          int el;
          in_frame = 0;
          check(!ferr, $sformatf("R2/R3/R6/R7 %s", fmsg));
          el = (exp_len_q.size() > 0) ? exp_len_q.pop_front() : -1;
          check(flen == el, $sformatf("R5 frame cycles actual=%0d expected=%0d", flen, el));
          have_prev = 1; low = 0; quiet_err = 0;
        end
        low++;
        if (mii_txd != 4'h0 || mii_tx_er || s_ready) quiet_err++;
      end
    end
  end

  task automatic send_frame(input int len, input int stall_pct, input int idle, input bit chk_start);
    logic [7:0] bytes[$];
    int stalls[$];
    int total;
    bit er_state;
    if (frames_sent > 0) exp_gap_q.push_back(exp_gap(idle));
    repeat (idle) @(negedge clk);
    for (int i = 0; i < 15; i++) begin
      exp_nib_q.push_back(4'h5); exp_er_q.push_back(0); exp_un_q.push_back(0);
    end
    exp_nib_q.push_back(4'hD); exp_er_q.push_back(0); exp_un_q.push_back(0);
    total = 16;
    er_state = 0;
    for (int k = 0; k < len; k++) begin
      int n;
      bytes.push_back(8'($urandom));
      n = (k > 0 && $urandom_range(99) < stall_pct) ? $urandom_range(3, 1) : 0;
      stalls.push_back(n);
      for (int f = 0; f < n; f++) begin
        exp_nib_q.push_back(4'h0); exp_er_q.push_back(1); exp_un_q.push_back(1);
      end
      if (n > 0) er_state = 1;
      exp_nib_q.push_back(bytes[k][3:0]); exp_er_q.push_back(er_state); exp_un_q.push_back(0);
      exp_nib_q.push_back(bytes[k][7:4]); exp_er_q.push_back(er_state); exp_un_q.push_back(0);
      total += 2 + n;
    end
    exp_len_q.push_back(total);
    for (int k = 0; k < len; k++) begin
      if (stalls[k] > 0) begin
        s_valid = 0;
        repeat (stalls[k]) @(negedge clk);
      end
      s_data = bytes[k]; s_valid = 1; s_last = (k == len - 1);
      if (k == 0 && chk_start) begin
        check(mii_tx_en == 0, $sformatf("R10 enable before start actual=%0d expected=0", mii_tx_en));
        @(negedge clk);
        check(mii_tx_en == 1 && mii_txd == 4'h5,
              $sformatf("R10 start latency actual=%0d/%h expected=1/5", mii_tx_en, mii_txd));
      end
      while (!s_ready) @(negedge clk);
      @(negedge clk);
    end
    s_valid = 0; s_last = 0;
    frames_sent++;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h0000_4d11));
    rst_n = 0; s_data = 8'h00; s_valid = 0; s_last = 0;
    repeat (3) @(negedge clk);
    // R1: outputs held at zero during reset
    check({mii_tx_en, mii_tx_er, mii_txd, s_ready} == 7'd0,
          $sformatf("R1 in reset actual=%b expected=0", {mii_tx_en, mii_tx_er, mii_txd, s_ready}));
    rst_n = 1;
    repeat (6) @(negedge clk);
    check({mii_tx_en, mii_tx_er, mii_txd, s_ready} == 7'd0,
          $sformatf("R1 after release actual=%b expected=0", {mii_tx_en, mii_tx_er, mii_txd, s_ready}));
    // R10: waits while no input, then starts one cycle after valid
    send_frame(4, 0, 0, 1);
    // R8: back-to-back short frame -> exactly 24 idle cycles; R9 valid held during gap
    send_frame(1, 0, 0, 0);
    // R6/R7: underrun before every byte after the first
    send_frame(6, 100, 0, 0);
    // R7: error cleared on next frame
    send_frame(3, 0, 0, 0);
    // R8: long idle -> gap longer than minimum
    send_frame(2, 0, 30, 0);
    // R8: offer arrives mid-gap
    send_frame(2, 0, 10, 0);
    for (int i = 0; i < 25; i++) begin
      int len; int sp; int idl;
      len = $urandom_range(24, 1);
      sp  = ($urandom_range(1) == 1) ? 30 : 0;
      idl = ($urandom_range(1) == 1) ? $urandom_range(40) : 0;
      send_frame(len, sp, idl, 0);
    end
    repeat (40) @(negedge clk);
    check(exp_len_q.size() == 0 && exp_nib_q.size() == 0,
          $sformatf("R5 frames left unsent actual=%0d expected=0", exp_len_q.size()));
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule